// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a register-driven master for the two-wire PHY management bus. Software fills in a command word and sets its launch bit. The command word holds the frame flavour (clause 22 or clause 45), a two-bit opcode, a five-bit PHY port address and a five-bit device or register address. The block then emits a complete 64-bit management frame on MDC/MDIO. For read opcodes it releases the data line and gathers the 16 bits that the PHY returns.

Progress is reported through the launch bit itself. The bit reads back as 1 while a frame is on the wire, and the hardware drops it once the frame and a quiet tail are finished. A sticky status flag records a read whose turnaround the PHY did not acknowledge, and software clears that flag by writing a 1 to it. The data phase of a clause 45 address frame comes from a dedicated address register. Write frames take their data phase from the write-data register.

The register port uses single-cycle write strobes and a read strobe whose data appears one clock later. MDC is a divided copy of the system clock. The data-line enable is intended to drive an external tristate pad.

Top module: `mdio_master`

## Requirements
- R1: Registers are selected by word index: 0 command, 1 clause 45 address, 2 write data, 3 read data, 4 status. The corresponding byte offsets are 0x0, 0x4, 0x8, 0xC and 0x10. A read strobe returns the selected register on `reg_rdata` one clock later, and the address and write-data registers read back what was written.
- R2: Command word fields are dev[4:0], port[9:5], opcode[11:10], frame type[13:12] and launch[14]. Writing it with bit 14 set starts a frame, and bit 14 reads as 1 until the frame ends. Writing it with bit 14 clear only stores the fields.
- R3: Each frame is 32 ones, then the two frame-type bits as the start pattern (00 for clause 45 when type is 0, 01 for clause 22 when type is 1), then opcode, port, dev, the turnaround bits 1 then 0, then 16 data bits. Every field is sent MSB first.
- R4: A clause 45 opcode 0 frame carries the address register as its data. Every other non-read frame carries the write-data register.
- R5: MDC has a period of 2*DIV_HALF system clocks. MDIO and its enable change only on the clock edge where MDC falls.
- R6: For reads (clause 22 opcode 2, clause 45 opcodes 2 and 3), the enable is low from frame bit 47 (the second turnaround bit) through bit 63. The data bits are sampled on MDC rising edges and stored in the read-data register.
- R7: A read whose bit 47 is sampled high sets status bit 0 on the same edge that clears the launch bit, and it leaves the read-data register unchanged. Status bit 0 holds until a status write with bit 0 set.
- R8: A command write while the launch bit is set has no effect on the stored command or on the frame in progress.
- R9: After bit 63 the enable drops on the next MDC fall. The launch bit clears exactly 3*DIV_HALF+1 clocks after the MDC rise of bit 63.
- R10: After reset, all registers read 0, the enable is low and no frame runs.
- R11: When a status clear write lands on the same clock as a failed read completing, the flag ends up set.
- R12: Clause 45 opcodes 2 and 3 both behave as reads with identical wire timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Word index of the register written |
| reg_wdata | input | 16 | Write data |
| reg_re | input | 1 | Register read strobe |
| reg_raddr | input | 3 | Word index of the register read |
| reg_rdata | output | 16 | Read data, valid one clock after the strobe |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data value driven onto the line |
| mdio_oe | output | 1 | Drive enable for the data line |

## Verification
Two things can happen on the same clock edge: a failing read completing, which sets the sticky flag, and a software write that clears that flag. The bench times its clear write from the MDC rise of the final data bit. It places the write exactly on the edge where the launch bit drops, and it reads the command word on that edge and the next to confirm the alignment. It then expects the flag to read 1, and a later standalone clear to bring it back to 0.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA2_BIT    = 47;
  localparam int DATA_W     = 16;
  localparam int WIDX_W     = 3;

  localparam logic [WIDX_W-1:0] IDX_CMD  = 3'd0;
  localparam logic [WIDX_W-1:0] IDX_ADDR = 3'd1;
  localparam logic [WIDX_W-1:0] IDX_WDAT = 3'd2;
  localparam logic [WIDX_W-1:0] IDX_RDAT = 3'd3;
  localparam logic [WIDX_W-1:0] IDX_STAT = 3'd4;

  localparam int LAUNCH_BIT = 14;

  typedef struct packed {
    logic [1:0] ft;
    logic [1:0] op;
    logic [4:0] prt;
    logic [4:0] dev;
  } mdio_cmd_t;

  function automatic logic cmd_is_read(mdio_cmd_t c);
    return (c.ft == 2'd0) ? c.op[1] : (c.op == 2'd2);
  endfunction

  function automatic logic cmd_uses_addr(mdio_cmd_t c);
    return (c.ft == 2'd0) && (c.op == 2'd0);
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_HALF = 20
) (
  input  logic clk,
  input  logic rst,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] div_cnt;
  logic          wrap;

  assign wrap      = (div_cnt == LAST);
  assign rise_tick = wrap & ~mdc;
  assign fall_tick = wrap & mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      mdc     <= 1'b0;
    end else if (wrap) begin
      div_cnt <= '0;
      mdc     <= ~mdc;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  AST_MDC_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdc) |-> $past(wrap)); // R5
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic [DATA_W-1:0] addr_data,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              rd_fail,
  output logic              rd_ok,
  output logic [DATA_W-1:0] rd_data
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2) + 1;
  localparam logic [CNT_W-1:0] N_BITS   = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] N_END    = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] TA2_IDX  = CNT_W'(TA2_BIT);
  localparam logic [CNT_W-1:0] TA2_SMP  = CNT_W'(TA2_BIT + 1);
  localparam logic [CNT_W-1:0] D0_SMP   = CNT_W'(TA2_BIT + 2);

  logic                  active;
  logic                  rd_mode;
  logic                  ta_bad;
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] frame_sr;
  logic [DATA_W-1:0]     cap_sr;
  logic [DATA_W-1:0]     phase_data;

  assign phase_data = cmd_uses_addr(cmd) ? addr_data : wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      rd_mode  <= 1'b0;
      ta_bad   <= 1'b0;
      bit_cnt  <= '0;
      frame_sr <= '0;
      cap_sr   <= '0;
      mdio_o   <= 1'b1;
      mdio_oe  <= 1'b0;
      done     <= 1'b0;
      rd_fail  <= 1'b0;
      rd_ok    <= 1'b0;
      rd_data  <= '0;
    end else begin
      done    <= 1'b0;
      rd_fail <= 1'b0;
      rd_ok   <= 1'b0;
      if (start && !active) begin
        active   <= 1'b1;
        rd_mode  <= cmd_is_read(cmd);
        ta_bad   <= 1'b0;
        bit_cnt  <= '0;
        frame_sr <= {32'hFFFF_FFFF, cmd.ft, cmd.op, cmd.prt, cmd.dev, 2'b10, phase_data};
      end else if (active && fall_tick) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt < N_BITS) begin
          mdio_o   <= frame_sr[FRAME_BITS-1];
          frame_sr <= {frame_sr[FRAME_BITS-2:0], 1'b1};
          mdio_oe  <= !(rd_mode && (bit_cnt >= TA2_IDX));
        end else if (bit_cnt == N_BITS) begin
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else if (bit_cnt == N_END) begin
          active  <= 1'b0;
          done    <= 1'b1;
          rd_fail <= rd_mode & ta_bad;
          rd_ok   <= rd_mode & ~ta_bad;
          rd_data <= cap_sr;
        end
      end else if (active && rise_tick) begin
        if (bit_cnt == TA2_SMP) ta_bad <= mdio_i;
        if (rd_mode && bit_cnt >= D0_SMP && bit_cnt <= N_BITS)
          cap_sr <= {cap_sr[DATA_W-2:0], mdio_i};
      end
    end
  end

  AST_OE_RISES_ON_FIRST_BIT: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> (bit_cnt == CNT_W'(1))); // R3
  AST_DONE_WITH_LINE_FREE: assert property (@(posedge clk) disable iff (rst)
    done |-> !mdio_oe); // R9
  AST_READ_LINE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (active && rd_mode && bit_cnt > TA2_SMP) |-> !mdio_oe); // R6
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_waddr,
  input  logic [15:0]       reg_wdata,
  input  logic              reg_re,
  input  logic [2:0]        reg_raddr,
  output logic [15:0]       reg_rdata,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);
  mdio_cmd_t         cmd_q;
  logic              busy;
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q;
  logic [DATA_W-1:0] rdat_q;
  logic              fail_q;
  logic              start;
  logic              rise_tick, fall_tick;
  logic              eng_done, eng_fail, eng_ok;
  logic [DATA_W-1:0] eng_data;
  mdio_cmd_t         wr_cmd;

  assign wr_cmd = mdio_cmd_t'(reg_wdata[13:0]);
  assign start  = reg_we && (reg_waddr == IDX_CMD) && !busy && reg_wdata[LAUNCH_BIT];

  mdio_clkgen #(.DIV_HALF(DIV_HALF)) clkgen_i (
    .clk(clk), .rst(rst), .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_eng eng_i (
    .clk(clk), .rst(rst), .start(start), .cmd(wr_cmd),
    .addr_data(addr_q), .wr_data(wdat_q),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(eng_done), .rd_fail(eng_fail), .rd_ok(eng_ok), .rd_data(eng_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      busy   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      fail_q <= 1'b0;
    end else begin
      if (reg_we && reg_waddr == IDX_CMD && !busy) cmd_q <= wr_cmd;
      if (reg_we && reg_waddr == IDX_ADDR) addr_q <= reg_wdata;
      if (reg_we && reg_waddr == IDX_WDAT) wdat_q <= reg_wdata;
      if (start)         busy <= 1'b1;
      else if (eng_done) busy <= 1'b0;
      if (eng_done && eng_fail)                           fail_q <= 1'b1;
      else if (reg_we && reg_waddr == IDX_STAT && reg_wdata[0]) fail_q <= 1'b0;
      if (eng_ok) rdat_q <= eng_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_re) begin
      case (reg_raddr)
        IDX_CMD:  reg_rdata <= {1'b0, busy, cmd_q};
        IDX_ADDR: reg_rdata <= addr_q;
        IDX_WDAT: reg_rdata <= wdat_q;
        IDX_RDAT: reg_rdata <= rdat_q;
        IDX_STAT: reg_rdata <= {15'd0, fail_q};
        default:  reg_rdata <= '0;
      endcase
    end
  end

  AST_LINE_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> $fell(mdc)); // R5
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start |=> busy); // R2
  AST_CMD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_we && reg_waddr == IDX_CMD) |=> $stable(cmd_q)); // R8
  AST_FAIL_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_q) |-> $fell(busy)); // R7
  AST_RELEASED_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !mdio_oe); // R9
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (eng_done && eng_fail) |=> fail_q); // R11
endmodule

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DH = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0]  reg_waddr = '0, reg_raddr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        phy_drv = 1'b1;
  logic        bus;

  assign bus = mdio_oe ? mdio_o : phy_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.DIV_HALF(DH)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_re(reg_re), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_i(bus), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  typedef struct {
    logic [63:0] f;
    bit          rd;
    bit          ta;
    logic [15:0] d;
    bit          w1c;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_err = 0;
  event launched, frame_end;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_re = 1'b1; reg_raddr = a;
    @(negedge clk); d = reg_rdata; reg_re = 1'b0;
  endtask

  function automatic logic [15:0] cmdw(bit go, logic [1:0] ft, logic [1:0] op,
                                       logic [4:0] prt, logic [4:0] dev);
    return {1'b0, go, ft, op, prt, dev};
  endfunction

  task automatic run(logic [1:0] ft, logic [1:0] op, logic [4:0] prt, logic [4:0] dev,
                     logic [15:0] data, bit rdf, bit ta, logic [15:0] rdat, bit w1c);
    exp_t e;
    e.f = {32'hFFFF_FFFF, ft, op, prt, dev, 2'b10, data};
    e.rd = rdf; e.ta = ta; e.d = rdat; e.w1c = w1c;
    q.push_back(e);
    wr(3'd0, cmdw(1'b1, ft, op, prt, dev));
    ->launched;
  endtask

  // Monitor: acts as PHY responder, decodes the wire and checks tail timing
  initial begin
    forever begin
      exp_t        e;
      logic [63:0] got;
      bit          oe_bad;
      logic [15:0] rv;
      @(launched);
      e = q.pop_front();
      got = '0; oe_bad = 0;
      for (int i = 0; i < 64; i++) begin
        @(negedge mdc);
        if (e.rd && i >= 47) phy_drv = (i == 47) ? e.ta : e.d[63-i];
        @(posedge mdc);
        got[63-i] = bus;
        if (e.rd && i >= 47) begin
          if (mdio_oe) oe_bad = 1;
        end else if (!mdio_oe) oe_bad = 1;
      end
      if (e.rd) check("R3 frame header on wire (read)", {got[63:17], 17'd0}, {e.f[63:17], 17'd0});
      else      check("R3/R4 frame on wire (write)", got, e.f);
      check("R6 line enable pattern", {63'd0, oe_bad}, 64'd0);
      repeat (3*DH) @(posedge clk);
      @(negedge clk);
      check("R9 line released before end", {63'd0, mdio_oe}, 64'd0);
      reg_re = 1'b1; reg_raddr = 3'd0;
      if (e.w1c) begin reg_we = 1'b1; reg_waddr = 3'd4; reg_wdata = 16'h0001; end
      @(negedge clk);
      rv = reg_rdata;
      reg_we = 1'b0;
      check("R9 launch bit still set at tail edge", {63'd0, rv[14]}, 64'd1);
      @(negedge clk);
      rv = reg_rdata;
      reg_re = 1'b0;
      check("R9 launch bit clears 3*DH+1 after last rise", {63'd0, rv[14]}, 64'd0);
      phy_drv = 1'b1;
      ->frame_end;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    realtime t0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R10 register zero after reset", {48'd0, v}, 64'd0);
    end
    check("R10 enable low after reset", {63'd0, mdio_oe}, 64'd0);

    @(posedge mdc); t0 = $realtime;
    @(posedge mdc);
    check("R5 MDC period", 64'($rtoi($realtime - t0)), 64'(2*DH*CLK_PERIOD));

    wr(3'd1, 16'hBEEF); rd(3'd1, v); check("R1 address reg readback", {48'd0, v}, 64'hBEEF);
    wr(3'd2, 16'hA5C3); rd(3'd2, v); check("R1 write-data reg readback", {48'd0, v}, 64'hA5C3);

    wr(3'd0, cmdw(1'b0, 2'd1, 2'd1, 5'h07, 5'h09));
    repeat (3) @(negedge clk);
    rd(3'd0, v); check("R2 store without launch", {48'd0, v}, {48'd0, cmdw(1'b0, 2'd1, 2'd1, 5'h07, 5'h09)});

    run(2'd1, 2'd1, 5'h0A, 5'h13, 16'hA5C3, 0, 0, 16'h0, 0);      // R3 clause 22 write
    @(frame_end);

    run(2'd1, 2'd2, 5'h1F, 5'h02, 16'h0, 1, 0, 16'h1234, 0);      // R6 clause 22 read
    @(frame_end);
    rd(3'd3, v); check("R6 read data captured", {48'd0, v}, 64'h1234);
    rd(3'd4, v); check("R7 no fail on good read", {48'd0, v}, 64'd0);

    wr(3'd2, 16'h1111);
    run(2'd0, 2'd0, 5'h01, 5'h03, 16'hBEEF, 0, 0, 16'h0, 0);      // R4 address frame
    @(frame_end);
    run(2'd0, 2'd1, 5'h01, 5'h03, 16'h1111, 0, 0, 16'h0, 0);      // R4 clause 45 write
    @(frame_end);

    run(2'd0, 2'd3, 5'h05, 5'h1E, 16'h0, 1, 0, 16'hCAFE, 0);      // R12 op3
    @(frame_end);
    rd(3'd3, v); check("R12 clause 45 read data", {48'd0, v}, 64'hCAFE);
    run(2'd0, 2'd2, 5'h05, 5'h1E, 16'h0, 1, 0, 16'h5555, 0);      // R12 op2
    @(frame_end);
    rd(3'd3, v); check("R12 clause 45 read-increment data", {48'd0, v}, 64'h5555);

    run(2'd1, 2'd2, 5'h02, 5'h04, 16'h0, 1, 1, 16'h9999, 1);      // R7/R11 failed read with clear
    @(frame_end);
    rd(3'd4, v); check("R11 set wins over same-edge clear", {48'd0, v}, 64'd1);
    rd(3'd3, v); check("R7 read data kept on fail", {48'd0, v}, 64'h5555);
    wr(3'd4, 16'h0001);
    rd(3'd4, v); check("R7 flag cleared by write of 1", {48'd0, v}, 64'd0);

    wr(3'd2, 16'h3C3C);
    run(2'd1, 2'd1, 5'h03, 5'h04, 16'h3C3C, 0, 0, 16'h0, 0);      // R8 base frame
    repeat (20) @(negedge clk);
    wr(3'd0, cmdw(1'b1, 2'd0, 2'd2, 5'h1E, 5'h1D));
    @(frame_end);
    repeat (4) @(negedge clk);
    rd(3'd0, v); check("R8 busy write ignored", {48'd0, v}, {48'd0, cmdw(1'b0, 2'd1, 2'd1, 5'h03, 5'h04)});

    finish_run();
  end
endmodule